// File: doc/BRIEF.md
# NAND flash bus cycle sequencer

This block turns single requests from a flash controller into the strobe sequences of an 8-bit raw NAND interface. It serves two flash groups. Each group has its own data bus, write and read strobes, command and address latch enables and ready/busy input. Both groups share a pool of eight active-low chip enables. All timing is counted in clock cycles, and one cycle stands for one interface period of about 33 ns.

The controller presents one request at a time through a valid/ready handshake. A request carries:
- an operation: command byte, address byte, data write or data read;
- a group select;
- a chip index;
- a write byte.

The sequencer applies the chip-enable lead, the latch-enable setup and hold, the strobe pulse and the recovery time. It then pulses `done`, and for a read it presents the captured byte on `rd_data`. When the next request goes to the same chip in the same group and arrives in the cycle of `done`, the chip enable stays low and the lead time is skipped.

The data bus is split into a driven value, a per-group output enable and a sampled input, for connection to a pad ring. The ready/busy inputs are synchronised and reported as per-group busy flags.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset every chip enable, write strobe and read strobe is high. Command and address latch enables, the data output enables and `done` are low. `grp_busy` is 0 and `req_ready` is 1.
- R2: Operation codes on `req_op`: 2'b00 is command, 2'b01 is address, 2'b10 is write data, 2'b11 is read. In the selected group, the latch enable for a command (`cle`) or an address (`ale`) is high, and for codes 00, 01 and 10 `dq_oe` is high with `dq_out` carrying `req_wdata`. These levels hold from the first cycle after acceptance through the hold cycle.
- R3: For a target whose chip enable is not already low, `ce_n[req_chip]` falls in the cycle after acceptance. It stays low for exactly three cycles before the strobe falls. At most one chip enable is low at any time.
- R4: For codes 00, 01 and 10, the selected group's `we_n` is low for exactly one cycle. At least one cycle of unchanged latch enables and data precedes it, and exactly one cycle follows it.
- R5: For a read, `re_n` is low for two cycles (one strobe period plus one access wait cycle) and `dq_oe` stays low. The byte on the group's `dq_in` at the clock edge that ends the low phase appears on `rd_data` in the `done` cycle.
- R6: `done` is high for exactly one cycle, the cycle after the hold cycle. `req_ready` is low from the cycle after acceptance through the hold cycle.
- R7: A request to the same chip and group that is accepted in the `done` cycle keeps the chip enable low. Its strobe falls after a single setup cycle.
- R8: When no request is accepted in the `done` cycle, all chip enables are high from the next cycle on. A request accepted there for a different chip or group swaps the chip enables at one edge and uses the full three-cycle lead.
- R9: `grp_busy[g]` is the inverse of `rb_n[g]` through a two-flop synchronizer. A change shows after the second rising edge and not after the first.
- R10: While `grp_busy[g]` is 1, a request to group g with code 01, 10 or 11 is refused: `req_ready` is low and no chip enable falls. A command request (code 00) to that group, and requests to the other group, are still accepted.
- R11: The group that is not selected keeps its strobes high, its latch enables low and its output enable low, and at most one strobe of all groups is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per interface period |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | Operation code (see R2) |
| req_grp | input | 1 | Target flash group |
| req_chip | input | 3 | Target chip-enable index |
| req_wdata | input | 8 | Command, address or data byte to send |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |
| grp_busy | output | 2 | Synchronised busy flag per group |
| ce_n | output | 8 | Chip enables, active low |
| we_n | output | 2 | Write strobe per group, active low |
| re_n | output | 2 | Read strobe per group, active low |
| cle | output | 2 | Command latch enable per group |
| ale | output | 2 | Address latch enable per group |
| dq_out | output | 16 | Data driven per group, group g on bits [8g+7:8g] |
| dq_oe | output | 2 | Data output enable per group |
| dq_in | input | 16 | Data sampled per group, same bit layout as dq_out |
| rb_n | input | 2 | Ready/busy per group, low means busy |

## Verification
The bench follows a run of requests to one chip issued back to back, where a design that always re-runs the lead would strobe two cycles late and a design that never releases the chip enable would leave it low through idle gaps. It moves the same chip index across groups and then to a new chip: a chip-enable pool that ignored the group would skip the lead and strobe too early. Reads run against a flash model that presents data only in the second low cycle of the read strobe, so capturing one edge early returns a marker byte instead of the data. A busy group is checked for the two-edge synchronizer delay, for refusal of a non-command request, and for acceptance of a command and of traffic to the other group.

// File: rtl/nss_pkg.sv
// Shared types of the NAND strobe sequencer.
// Assumes: operation codes are fixed by the request interface.
package nss_pkg;

    typedef enum logic [1:0] {
        OP_CMD  = 2'b00,
        OP_ADDR = 2'b01,
        OP_WR   = 2'b10,
        OP_RD   = 2'b11
    } nss_op_e;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_LEAD   = 3'd1,
        PH_SETUP  = 3'd2,
        PH_STROBE = 3'd3,
        PH_RWAIT  = 3'd4,
        PH_HOLD   = 3'd5
    } nss_phase_e;

endpackage

// File: rtl/nss_rb_sync.sv
// Ready/busy synchronizer for one flash group.
// Brings the asynchronous ready/busy pin into the clock domain through a
// chain of STAGES flops and reports busy (the pin low) from the last flop.
// Assumes: STAGES >= 2; the chain resets to "ready".
module nss_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_i,
    output logic busy_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], rb_n_i};
        end
    end

    assign busy_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/nss_ce_pool.sv
// Chip-enable pool shared by all flash groups.
// Holds at most one active target (chip index plus group). A new target is
// taken on request acceptance; the enable is dropped at the end of any idle
// cycle in which nothing is accepted. hit_o tells whether the offered
// target is already enabled so the lead time can be skipped.
// Assumes: take_i only pulses while the sequencer is idle.
module nss_ce_pool #(
    parameter int NCE  = 8,
    parameter int NGRP = 2,
    localparam int CHW = $clog2(NCE),
    localparam int GW  = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           idle_i,
    input  logic           take_i,
    input  logic [CHW-1:0] chip_i,
    input  logic [GW-1:0]  grp_i,
    output logic           hit_o,
    output logic [NCE-1:0] ce_n_o
);

    logic           on_q;
    logic [CHW-1:0] idx_q;
    logic [GW-1:0]  grp_q;

    // Take a new target on acceptance, drop it after an empty idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q  <= 1'b0;
            idx_q <= '0;
            grp_q <= '0;
        end else if (take_i) begin
            on_q  <= 1'b1;
            idx_q <= chip_i;
            grp_q <= grp_i;
        end else if (idle_i) begin
            on_q  <= 1'b0;
        end
    end

    assign hit_o = on_q && (idx_q == chip_i) && (grp_q == grp_i);

    // One decoded active-low enable per pool line.
    for (genvar i = 0; i < NCE; i++) begin : g_ce
        assign ce_n_o[i] = ~(on_q && (idx_q == CHW'(i)));
    end

    // R8: an idle cycle with no acceptance leaves every enable high next cycle.
    p_ce_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && !take_i) |=> (ce_n_o == '1));

endmodule

// File: rtl/nss_phase_fsm.sv
// Phase sequencer of one bus cycle.
// Walks lead -> setup -> strobe -> (read wait) -> hold, each phase lasting a
// parameter number of clock periods, and pulses done_o one cycle after the
// hold phase ends. The lead phase is skipped when the target is already
// enabled (hit_i).
// Assumes: LEAD_CYC > SETUP_CYC >= 1, PULSE_CYC >= 1, HOLD_CYC >= 1.
module nss_phase_fsm
    import nss_pkg::*;
#(
    parameter int LEAD_CYC    = 3,
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 1,
    parameter int RD_WAIT_CYC = 1,
    parameter int HOLD_CYC    = 1,
    localparam int SUM_CYC    = LEAD_CYC + PULSE_CYC + RD_WAIT_CYC + HOLD_CYC,
    localparam int CW         = $clog2(SUM_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       hit_i,
    input  logic       is_rd_i,
    output nss_phase_e phase_o,
    output logic       last_o,
    output logic       done_o
);

    nss_phase_e    phase_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Advance through the phases and count the periods of each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (phase_q == PH_HOLD) && (cnt_q == '0);
            if (phase_q == PH_IDLE) begin
                if (start_i) begin
                    if (hit_i) begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= CW'(SETUP_CYC - 1);
                    end else begin
                        phase_q <= PH_LEAD;
                        cnt_q   <= CW'(LEAD_CYC - SETUP_CYC - 1);
                    end
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                case (phase_q)
                    PH_LEAD: begin
                        phase_q <= PH_SETUP;
                        cnt_q   <= CW'(SETUP_CYC - 1);
                    end
                    PH_SETUP: begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= CW'(PULSE_CYC - 1);
                    end
                    PH_STROBE: begin
                        if (is_rd_i && (RD_WAIT_CYC > 0)) begin
                            phase_q <= PH_RWAIT;
                            cnt_q   <= CW'(RD_WAIT_CYC - 1);
                        end else begin
                            phase_q <= PH_HOLD;
                            cnt_q   <= CW'(HOLD_CYC - 1);
                        end
                    end
                    PH_RWAIT: begin
                        phase_q <= PH_HOLD;
                        cnt_q   <= CW'(HOLD_CYC - 1);
                    end
                    default: begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end
                endcase
            end
        end
    end

    assign phase_o = phase_q;
    assign last_o  = (cnt_q == '0);
    assign done_o  = done_q;

    // R4: a strobe phase is always entered from the setup phase.
    p_strobe_after_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE && $past(phase_q) != PH_STROBE) |-> ($past(phase_q) == PH_SETUP));

endmodule

// File: rtl/nand_strobe_seq.sv
// NAND flash bus cycle sequencer, top level.
// Accepts one request at a time (valid/ready), latches it, runs the phase
// sequencer and decodes per-group strobes, latch enables and data drive.
// Read data is captured at the edge that ends the read-strobe low phase.
// Assumes: dq_out/dq_oe/dq_in connect to bidirectional pads outside;
// rb_n pins are asynchronous.
module nand_strobe_seq
    import nss_pkg::*;
#(
    parameter int DW          = 8,
    parameter int NGRP        = 2,
    parameter int NCE         = 8,
    parameter int LEAD_CYC    = 3,
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 1,
    parameter int RD_WAIT_CYC = 1,
    parameter int HOLD_CYC    = 1,
    parameter int SYNC_STAGES = 2,
    localparam int CHW        = $clog2(NCE),
    localparam int GW         = (NGRP > 1) ? $clog2(NGRP) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [GW-1:0]      req_grp,
    input  logic [CHW-1:0]     req_chip,
    input  logic [DW-1:0]      req_wdata,
    output logic               done,
    output logic [DW-1:0]      rd_data,
    output logic [NGRP-1:0]    grp_busy,
    output logic [NCE-1:0]     ce_n,
    output logic [NGRP-1:0]    we_n,
    output logic [NGRP-1:0]    re_n,
    output logic [NGRP-1:0]    cle,
    output logic [NGRP-1:0]    ale,
    output logic [NGRP*DW-1:0] dq_out,
    output logic [NGRP-1:0]    dq_oe,
    input  logic [NGRP*DW-1:0] dq_in,
    input  logic [NGRP-1:0]    rb_n
);

    nss_phase_e     phase;
    logic           last;
    logic           hit;
    logic           accept;
    logic           allowed;
    logic           active;
    logic           capture;
    nss_op_e        op_q;
    logic [GW-1:0]  grp_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  rd_q;

    // One synchronizer per group for the ready/busy pins.
    for (genvar g = 0; g < NGRP; g++) begin : g_sync
        nss_rb_sync #(.STAGES(SYNC_STAGES)) i_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .rb_n_i (rb_n[g]),
            .busy_o (grp_busy[g])
        );
    end

    assign allowed   = (nss_op_e'(req_op) == OP_CMD) || !grp_busy[req_grp];
    assign req_ready = (phase == PH_IDLE) && allowed;
    assign accept    = req_valid && req_ready;
    assign active    = (phase != PH_IDLE);

    nss_ce_pool #(.NCE(NCE), .NGRP(NGRP)) i_pool (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle_i (phase == PH_IDLE),
        .take_i (accept),
        .chip_i (req_chip),
        .grp_i  (req_grp),
        .hit_o  (hit),
        .ce_n_o (ce_n)
    );

    nss_phase_fsm #(
        .LEAD_CYC    (LEAD_CYC),
        .SETUP_CYC   (SETUP_CYC),
        .PULSE_CYC   (PULSE_CYC),
        .RD_WAIT_CYC (RD_WAIT_CYC),
        .HOLD_CYC    (HOLD_CYC)
    ) i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .hit_i   (hit),
        .is_rd_i (op_q == OP_RD),
        .phase_o (phase),
        .last_o  (last),
        .done_o  (done)
    );

    // Latch the accepted request for the whole bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_CMD;
            grp_q   <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_q    <= nss_op_e'(req_op);
            grp_q   <= req_grp;
            wdata_q <= req_wdata;
        end
    end

    assign capture = (op_q == OP_RD) && last &&
                     ((RD_WAIT_CYC > 0) ? (phase == PH_RWAIT) : (phase == PH_STROBE));

    // Capture the read byte at the edge that closes the read-strobe low phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (capture) begin
            rd_q <= dq_in[grp_q*DW +: DW];
        end
    end

    assign rd_data = rd_q;

    // Per-group decode of strobes, latch enables and data drive.
    for (genvar g = 0; g < NGRP; g++) begin : g_lane
        logic sel;
        assign sel  = active && (grp_q == GW'(g));
        assign we_n[g]  = ~(sel && (phase == PH_STROBE) && (op_q != OP_RD));
        assign re_n[g]  = ~(sel && (op_q == OP_RD) &&
                            ((phase == PH_STROBE) || (phase == PH_RWAIT)));
        assign cle[g]   = sel && (op_q == OP_CMD);
        assign ale[g]   = sel && (op_q == OP_ADDR);
        assign dq_oe[g] = sel && (op_q != OP_RD);
        assign dq_out[g*DW +: DW] = wdata_q;
    end

    // R3: never more than one chip enable low.
    p_ce_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    // R3: a strobe is only low while some chip enable is low.
    p_strobe_with_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((we_n & re_n) != '1) |-> (ce_n != '1));

    // R11: at most one strobe low across all groups.
    p_single_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~{we_n, re_n}) <= 1);

    // R6: done is a single-cycle pulse.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a group never drives its bus while its read strobe is low.
    p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dq_oe & ~re_n) == '0));

    // R10: non-command requests to a busy group are never offered ready.
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && nss_op_e'(req_op) != OP_CMD && grp_busy[req_grp]) |-> !req_ready);

endmodule

// File: tb/test_nand_strobe_seq.sv
`timescale 1ns/1ps
// Bench for the NAND strobe sequencer: per-request cycle-by-cycle expected
// waveform built from the requirements, compared on every falling edge.
module test_nand_strobe_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [0:0]  req_grp = 1'b0;
    logic [2:0]  req_chip = 3'd0;
    logic [7:0]  req_wdata = 8'h00;
    logic        done;
    logic [7:0]  rd_data;
    logic [1:0]  grp_busy;
    logic [7:0]  ce_n;
    logic [1:0]  we_n, re_n, cle, ale, dq_oe;
    logic [15:0] dq_out;
    logic [15:0] dq_in = 16'hEEEE;
    logic [1:0]  rb_n = 2'b11;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // Bench-side target tracking for the chip-enable hold rule.
    bit held = 0;
    int h_g = 0;
    int h_chip = 0;

    // Flash read model: data appears only in the second low cycle of re_n.
    logic [7:0] fval [2];
    int rlow [2];

    always #2.5 clk = ~clk;

    nand_strobe_seq i_nand_strobe_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_grp(req_grp), .req_chip(req_chip), .req_wdata(req_wdata),
        .done(done), .rd_data(rd_data), .grp_busy(grp_busy),
        .ce_n(ce_n), .we_n(we_n), .re_n(re_n), .cle(cle), .ale(ale),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in), .rb_n(rb_n)
    );

    initial begin
        fval[0] = 8'h00; fval[1] = 8'h00;
        rlow[0] = 0; rlow[1] = 0;
    end

    always @(negedge clk) begin
        for (int g = 0; g < 2; g++) begin
            if (re_n[g] == 1'b0) rlow[g] = rlow[g] + 1;
            else rlow[g] = 0;
            dq_in[g*8 +: 8] = (rlow[g] >= 2) ? fval[g] : 8'hEE;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_idle(input string req);
        chk(ce_n == 8'hFF, req, "ce_n idle", 16'(ce_n), 16'hFF);
        chk(we_n == 2'b11 && re_n == 2'b11, req, "strobes idle", 16'({we_n, re_n}), 16'hF);
        chk(cle == 2'b00 && ale == 2'b00 && dq_oe == 2'b00, req, "latch/oe idle",
            16'({cle, ale, dq_oe}), 16'h0);
        chk(done == 1'b0, req, "done idle", 16'(done), 16'h0);
    endtask

    // Run one request and compare every cycle until its done pulse.
    task automatic do_op(input logic [1:0] op, input int g, input int chip,
                         input logic [7:0] wd, input logic [7:0] rdv);
        bit fast;
        bit rd;
        int nlead, total, og;
        logic [7:0] exp_ce;
        fast = held && (g == h_g) && (chip == h_chip);
        rd = (op == 2'b11);
        og = 1 - g;
        fval[g] = rdv;
        req_op = op; req_grp = 1'(g); req_chip = 3'(chip); req_wdata = wd;
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R10", "ready at request", 16'(req_ready), 16'h1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        nlead = fast ? 0 : 2;
        total = nlead + 3 + (rd ? 1 : 0);
        exp_ce = ~(8'h01 << chip);
        for (int k = 0; k < total; k++) begin
            bit strobe, rwait;
            if (k > 0) @(negedge clk);
            strobe = (k == nlead + 1);
            rwait  = rd && (k == nlead + 2);
            chk(ce_n == exp_ce, fast ? "R7" : "R3", "ce_n", 16'(ce_n), 16'(exp_ce));
            chk(we_n[g] == !(strobe && !rd), "R4", "we_n", 16'(we_n[g]), 16'(!(strobe && !rd)));
            chk(re_n[g] == !(rd && (strobe || rwait)), "R5", "re_n",
                16'(re_n[g]), 16'(!(rd && (strobe || rwait))));
            chk(cle[g] == (op == 2'b00) && ale[g] == (op == 2'b01), "R2", "cle/ale",
                16'({cle[g], ale[g]}), 16'({op == 2'b00, op == 2'b01}));
            chk(dq_oe[g] == !rd, "R2", "dq_oe", 16'(dq_oe[g]), 16'(!rd));
            if (!rd) chk(dq_out[g*8 +: 8] == wd, "R2", "dq_out", 16'(dq_out[g*8 +: 8]), 16'(wd));
            chk(we_n[og] && re_n[og] && !cle[og] && !ale[og] && !dq_oe[og], "R11",
                "other group", 16'({we_n[og], re_n[og], cle[og], ale[og], dq_oe[og]}), 16'h18);
            chk(done == 1'b0 && req_ready == 1'b0, "R6", "done/ready in cycle",
                16'({done, req_ready}), 16'h0);
        end
        @(negedge clk);
        chk(done == 1'b1, "R6", "done pulse", 16'(done), 16'h1);
        chk(ce_n == exp_ce, "R7", "ce held in done cycle", 16'(ce_n), 16'(exp_ce));
        chk(we_n == 2'b11 && re_n == 2'b11, "R4", "strobes high in done cycle",
            16'({we_n, re_n}), 16'hF);
        if (rd) chk(rd_data == rdv, "R5", "rd_data", 16'(rd_data), 16'(rdv));
        held = 1; h_g = g; h_chip = chip;
    endtask

    task automatic idle_gap(input int n);
        held = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_idle("R8");
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_idle("R1");
        chk(grp_busy == 2'b00, "R1", "busy after reset", 16'(grp_busy), 16'h0);
        chk(req_ready == 1'b1, "R1", "ready after reset", 16'(req_ready), 16'h1);

        // Burst to one chip: command, two addresses, data (R7 after the first).
        do_op(2'b00, 0, 0, 8'h80, 8'h00);
        do_op(2'b01, 0, 0, 8'h12, 8'h00);
        do_op(2'b01, 0, 0, 8'h34, 8'h00);
        do_op(2'b10, 0, 0, 8'hA5, 8'h00);
        idle_gap(2);

        // Reads on group 1, then chip change and group change (R5, R8).
        do_op(2'b11, 1, 3, 8'h00, 8'h5C);
        do_op(2'b11, 1, 3, 8'h00, 8'hC3);
        do_op(2'b10, 1, 6, 8'h3C, 8'h00);
        do_op(2'b00, 0, 6, 8'h90, 8'h00);
        idle_gap(3);

        // R9: two-edge synchronizer latency.
        rb_n[1] = 1'b0;
        @(negedge clk);
        chk(grp_busy == 2'b00, "R9", "busy after one edge", 16'(grp_busy), 16'h0);
        @(negedge clk);
        chk(grp_busy == 2'b10, "R9", "busy after two edges", 16'(grp_busy), 16'h2);

        // R10: non-command to busy group is refused.
        req_op = 2'b10; req_grp = 1'b1; req_chip = 3'd2; req_wdata = 8'h11;
        req_valid = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R10", "ready for busy group", 16'(req_ready), 16'h0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_idle("R10");
        end
        req_valid = 1'b0;
        held = 0;
        do_op(2'b00, 1, 5, 8'h70, 8'h00);
        do_op(2'b10, 0, 1, 8'h66, 8'h00);
        idle_gap(1);

        rb_n[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(grp_busy == 2'b00, "R9", "busy cleared", 16'(grp_busy), 16'h0);
        do_op(2'b11, 1, 7, 8'h00, 8'hB4);
        idle_gap(2);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule